// File: doc/BRIEF.md
# Rate-Multiplier Line Stepper

This block draws one straight line on a 1024 x 1024 raster. It does this by stepping a horizontal and a vertical position counter under the control of a binary rate multiplier. A vector word carries a signed X component, a signed Y component, an intensify flag and an escape flag. When the block is idle it accepts the word together with a scale and a single/continue selection. It then runs a loop in which each iteration has an intensify interval, one count pulse and a sequence interval. On every count pulse each axis takes a step whenever the multiplier transition picks a set bit of that axis's magnitude. As a result, one pass of the multiplier moves each axis by exactly its component.

Word fetch and mode decoding sit outside this block. The surrounding logic presets the start position, hands over the word and reacts to the terminal pulses:
- done (more data wanted)
- escape (return to parameter decoding)
- edge interrupt
- pen interrupt

In continue mode the multiplier wraps and redraws the same segment until an edge is crossed.

Top module: `vec_stepper`

## Requirements
- R1: A word is accepted by `start_i` only while `busy_o` is low. In the word, bits [17:10] hold the X component and bits [9:2] hold the Y component, each as sign-magnitude with bit 7 of the byte set meaning negative. Bit 1 is intensify and bit 0 is escape. A position preset by `pos_set_i` is taken only while idle.
- R2: The 7-bit multiplier starts at zero and advances by 2^s on each count pulse. Here s is the number of leading zeros of the larger 7-bit magnitude, capped at 4. One pass therefore lasts 128>>s count pulses, and each axis moves exactly its magnitude in steps during a pass.
- R3: Each loop iteration is INT_CYC cycles of intensify interval, then the count pulse, then SEQ_CYC cycles of sequence interval. A completed single vector keeps `busy_o` high for exactly (pass length) x (INT_CYC+SEQ_CYC) cycles.
- R4: Each step adds or subtracts 2^scale units (scale 0..3) on its axis. A negative sign subtracts. Positions hold when there is no step and no preset.
- R5: `unblank_o` is high only during intensify intervals that come after the first count pulse, and only when the intensify bit is set. The starting point is never lit.
- R6: In single mode, a step that would take a position below 0 or above 1023 ends the vector with one-cycle `edge_irq_o` and `esc_o` pulses and no `done_o`.
- R7: In single mode, when the multiplier wraps, the block goes idle with a one-cycle `done_o` pulse. `esc_o` pulses with it exactly when the escape bit is set.
- R8: In continue mode, the multiplier wrap starts another identical pass. An edge crossing ends the run with `done_o` and `esc_o` and never with `edge_irq_o`.
- R9: While `pen_en_i` is high, a `pen_hit_i` during a run stops the loop at the end of the current sequence interval. The block then goes idle with a `pen_irq_o` pulse and no `done_o`.
- R10: After reset both positions are 0 and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Accept `word_i` and begin a line |
| word_i | input | 18 | Vector word |
| cont_i | input | 1 | Continue mode when high |
| scale_i | input | 2 | Step size is 2^scale units |
| pos_set_i | input | 1 | Preset the positions while idle |
| pos_x_i | input | POS_W | Preset X |
| pos_y_i | input | POS_W | Preset Y |
| pen_en_i | input | 1 | Light-pen enable |
| pen_hit_i | input | 1 | Light pen saw the spot |
| pos_x_o | output | POS_W | X position |
| pos_y_o | output | POS_W | Y position |
| unblank_o | output | 1 | Beam on |
| busy_o | output | 1 | Line in progress |
| done_o | output | 1 | Pulse: line finished, data wanted |
| esc_o | output | 1 | Pulse: return to parameter decoding |
| edge_irq_o | output | 1 | Pulse: raster edge crossed (single mode) |
| pen_irq_o | output | 1 | Pulse: stopped by light pen |

## Verification
The bench builds the block with POS_W=10, INT_CYC=2 and SEQ_CYC=3, so one loop is five cycles. With these values a full 128-pulse pass and a continue run spanning several passes both complete in a few thousand cycles. This makes exact busy-length checks for every pass length feasible. The 10-bit positions combined with scale 3 make edge crossings in both directions and on both axes reachable within a few dozen steps.

// File: rtl/vs_pkg.sv
package vs_pkg;
  localparam int MAG_W    = 7;
  localparam int MAX_SKIP = 4;
  localparam int WORD_W   = 18;

  typedef struct packed {
    logic             neg;
    logic [MAG_W-1:0] mag;
  } comp_t;

  typedef enum logic [1:0] {ST_IDLE, ST_INT, ST_SEQ} state_e;
endpackage

// File: rtl/vs_rate_mult.sv
module vs_rate_mult #(
  parameter int MAG_W    = 7,
  parameter int MAX_SKIP = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  clr_i,
  input  logic                  pulse_i,
  input  logic [1:0][MAG_W-1:0] mag_i,
  output logic [1:0]            step_o,
  output logic                  wrap_o
);
  logic [MAG_W-1:0]       acc_q, larger, rise;
  logic [MAG_W:0]         inc, sum;
  logic [1:0][MAG_W-1:0]  mag_rev;
  int                     lz;

  always_comb begin
    larger = (mag_i[0] > mag_i[1]) ? mag_i[0] : mag_i[1];
    lz = MAG_W;
    for (int b = 0; b < MAG_W; b++)
      if (larger[b]) lz = MAG_W - 1 - b;
    if (lz > MAX_SKIP) lz = MAX_SKIP;
    inc  = (MAG_W+1)'(1) << lz;
    sum  = {1'b0, acc_q} + inc;
    rise = sum[MAG_W-1:0] & ~acc_q;
  end

  // counter LSB pairs with magnitude MSB
  for (genvar g = 0; g < 2; g++) begin : g_axis
    for (genvar b = 0; b < MAG_W; b++) begin : g_bit
      assign mag_rev[g][b] = mag_i[g][MAG_W-1-b];
    end
    assign step_o[g] = |(rise & mag_rev[g]);
  end

  assign wrap_o = sum[MAG_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      acc_q <= '0;
    else if (clr_i)   acc_q <= '0;
    else if (pulse_i) acc_q <= sum[MAG_W-1:0];
  end

  AST_ONE_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_i |-> $onehot0(rise)); // R2
  AST_WRAP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_i && wrap_o) |-> (step_o == 2'b00)); // R2
endmodule

// File: rtl/vs_axis.sv
module vs_axis #(
  parameter int POS_W   = 10,
  parameter int SCALE_W = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [POS_W-1:0]   load_val_i,
  input  logic               step_i,
  input  logic               neg_i,
  input  logic [SCALE_W-1:0] scale_i,
  input  logic               clr_edge_i,
  output logic [POS_W-1:0]   pos_o,
  output logic               edge_o
);
  logic [POS_W-1:0] pos_q;
  logic [POS_W:0]   amt, nxt;
  logic             edge_q;

  always_comb begin
    amt = (POS_W+1)'(1) << scale_i;
    nxt = neg_i ? ({1'b0, pos_q} - amt) : ({1'b0, pos_q} + amt);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q  <= '0;
      edge_q <= 1'b0;
    end else begin
      if (load_i)      pos_q <= load_val_i;
      else if (step_i) pos_q <= nxt[POS_W-1:0];
      if (clr_edge_i)                edge_q <= 1'b0;
      else if (step_i && nxt[POS_W]) edge_q <= 1'b1;  // carry/borrow out = off raster
    end
  end

  assign pos_o  = pos_q;
  assign edge_o = edge_q;

  AST_POS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !load_i) |=> $stable(pos_o)); // R4
  AST_EDGE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(edge_o) |-> $past(step_i)); // R6
endmodule

// File: rtl/vec_stepper.sv
module vec_stepper #(
  parameter int POS_W   = 10,
  parameter int INT_CYC = 2,
  parameter int SEQ_CYC = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [17:0]      word_i,
  input  logic             cont_i,
  input  logic [1:0]       scale_i,
  input  logic             pos_set_i,
  input  logic [POS_W-1:0] pos_x_i,
  input  logic [POS_W-1:0] pos_y_i,
  input  logic             pen_en_i,
  input  logic             pen_hit_i,
  output logic [POS_W-1:0] pos_x_o,
  output logic [POS_W-1:0] pos_y_o,
  output logic             unblank_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             esc_o,
  output logic             edge_irq_o,
  output logic             pen_irq_o
);
  import vs_pkg::*;

  localparam int CNT_MAX = (INT_CYC > SEQ_CYC) ? INT_CYC : SEQ_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX) + 1;

  state_e               state_q;
  logic [CNT_W-1:0]     cnt_q;
  comp_t                comp_q [2];
  logic                 intens_q, esc_bit_q, cont_q, moved_q, pen_q, wrap_q;
  logic [1:0]           scale_q;
  logic                 done_q, esc_q, edge_irq_q, pen_irq_q;
  logic                 start_acc, pulse, wrap, pos_load;
  logic [1:0]           step, edge_hit;
  logic [1:0][MAG_W-1:0] mags;
  logic [POS_W-1:0]     pos_in [2];
  logic [POS_W-1:0]     pos [2];

  assign start_acc = start_i && (state_q == ST_IDLE);
  assign pos_load  = pos_set_i && (state_q == ST_IDLE);
  assign pulse     = (state_q == ST_INT) && (cnt_q == '0);
  assign pos_in[0] = pos_x_i;
  assign pos_in[1] = pos_y_i;

  vs_rate_mult #(.MAG_W(MAG_W), .MAX_SKIP(MAX_SKIP)) u_brm (
    .clk_i, .rst_ni,
    .clr_i   (start_acc),
    .pulse_i (pulse),
    .mag_i   (mags),
    .step_o  (step),
    .wrap_o  (wrap)
  );

  for (genvar g = 0; g < 2; g++) begin : g_ax
    assign mags[g] = comp_q[g].mag;
    vs_axis #(.POS_W(POS_W), .SCALE_W(2)) u_axis (
      .clk_i, .rst_ni,
      .load_i     (pos_load),
      .load_val_i (pos_in[g]),
      .step_i     (pulse && step[g]),
      .neg_i      (comp_q[g].neg),
      .scale_i    (scale_q),
      .clr_edge_i (start_acc),
      .pos_o      (pos[g]),
      .edge_o     (edge_hit[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      comp_q[0]  <= '0;
      comp_q[1]  <= '0;
      intens_q   <= 1'b0;
      esc_bit_q  <= 1'b0;
      cont_q     <= 1'b0;
      scale_q    <= '0;
      moved_q    <= 1'b0;
      pen_q      <= 1'b0;
      wrap_q     <= 1'b0;
      done_q     <= 1'b0;
      esc_q      <= 1'b0;
      edge_irq_q <= 1'b0;
      pen_irq_q  <= 1'b0;
    end else begin
      done_q     <= 1'b0;
      esc_q      <= 1'b0;
      edge_irq_q <= 1'b0;
      pen_irq_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          comp_q[0] <= word_i[17:10];
          comp_q[1] <= word_i[9:2];
          intens_q  <= word_i[1];
          esc_bit_q <= word_i[0];
          cont_q    <= cont_i;
          scale_q   <= scale_i;
          moved_q   <= 1'b0;
          pen_q     <= 1'b0;
          wrap_q    <= 1'b0;
          cnt_q     <= CNT_W'(INT_CYC - 1);
          state_q   <= ST_INT;
        end
        ST_INT: if (cnt_q == '0) begin
          moved_q <= 1'b1;
          wrap_q  <= wrap;
          cnt_q   <= CNT_W'(SEQ_CYC - 1);
          state_q <= ST_SEQ;
        end else cnt_q <= cnt_q - 1'b1;
        ST_SEQ: if (cnt_q == '0) begin
          if (|edge_hit) begin
            esc_q   <= 1'b1;
            if (cont_q) done_q <= 1'b1;
            else        edge_irq_q <= 1'b1;
            state_q <= ST_IDLE;
          end else if (pen_q) begin
            pen_irq_q <= 1'b1;
            state_q   <= ST_IDLE;
          end else if (wrap_q && !cont_q) begin
            done_q  <= 1'b1;
            esc_q   <= esc_bit_q;
            state_q <= ST_IDLE;
          end else begin
            cnt_q   <= CNT_W'(INT_CYC - 1);
            state_q <= ST_INT;
          end
        end else cnt_q <= cnt_q - 1'b1;
        default: state_q <= ST_IDLE;
      endcase
      if (state_q != ST_IDLE && pen_en_i && pen_hit_i) pen_q <= 1'b1;
    end
  end

  assign pos_x_o    = pos[0];
  assign pos_y_o    = pos[1];
  assign unblank_o  = (state_q == ST_INT) && moved_q && intens_q;
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;
  assign esc_o      = esc_q;
  assign edge_irq_o = edge_irq_q;
  assign pen_irq_o  = pen_irq_q;

  AST_FIRST_DARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_acc |=> !unblank_o); // R5
  AST_EDGE_NO_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_irq_o |-> (!done_o && esc_o)); // R6
  AST_HALT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || edge_irq_o || pen_irq_o) |-> !busy_o); // R7
  AST_CONT_NO_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cont_q |-> !edge_irq_o); // R8
  AST_IDLE_DARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !unblank_o); // R5
endmodule

// File: tb/tb_vec_stepper.sv
module tb_vec_stepper;
  localparam int INT_C = 2;
  localparam int SEQ_C = 3;
  localparam int LOOP  = INT_C + SEQ_C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0, cont_i = 1'b0, pos_set_i = 1'b0;
  logic        pen_en_i = 1'b0, pen_hit_i = 1'b0;
  logic [17:0] word_i = '0;
  logic [1:0]  scale_i = '0;
  logic [9:0]  pos_x_i = '0, pos_y_i = '0, pos_x_o, pos_y_o;
  logic        unblank_o, busy_o, done_o, esc_o, edge_irq_o, pen_irq_o;

  vec_stepper #(.POS_W(10), .INT_CYC(INT_C), .SEQ_CYC(SEQ_C)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i, .word_i, .cont_i, .scale_i,
    .pos_set_i, .pos_x_i, .pos_y_i, .pen_en_i, .pen_hit_i,
    .pos_x_o, .pos_y_o, .unblank_o, .busy_o, .done_o, .esc_o,
    .edge_irq_o, .pen_irq_o
  );

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  int m_done = 0, m_esc = 0, m_edge = 0, m_pen = 0, m_unb = 0, m_busy = 0;
  logic prev_unb = 1'b0;

  always @(negedge clk) begin
    if (done_o) m_done++;
    if (esc_o) m_esc++;
    if (edge_irq_o) m_edge++;
    if (pen_irq_o) m_pen++;
    if (busy_o) m_busy++;
    if (unblank_o && !prev_unb) m_unb++;
    prev_unb <= unblank_o;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int pass_len(input int mx, input int my);
    int m = (mx > my) ? mx : my;
    int lz = 0;
    for (int b = 6; b >= 0; b--) begin
      if ((m >> b) & 1) break;
      lz++;
    end
    if (lz > 4) lz = 4;
    return 128 >> lz;
  endfunction

  int r_done, r_esc, r_edge, r_pen, r_unb, r_busy;

  task automatic run(input logic [17:0] w, input logic cont, input logic [1:0] sc,
                     input int x0, input int y0, input logic pen_en, input int hit_at);
    int d0, e0, g0, p0, u0, b0, n;
    @(negedge clk); #1;
    d0 = m_done; e0 = m_esc; g0 = m_edge; p0 = m_pen; u0 = m_unb; b0 = m_busy;
    pos_set_i = 1'b1; pos_x_i = 10'(x0); pos_y_i = 10'(y0); pen_en_i = pen_en;
    @(negedge clk);
    pos_set_i = 1'b0; word_i = w; cont_i = cont; scale_i = sc; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    n = 0;
    while (busy_o) begin
      @(negedge clk);
      n++;
      pen_hit_i = (n == hit_at);
      if (n > 40000) begin
        chk("watchdog", "run cycles", n, 0);
        break;
      end
    end
    pen_hit_i = 1'b0;
    @(negedge clk); @(negedge clk); #1;
    r_done = m_done - d0; r_esc = m_esc - e0; r_edge = m_edge - g0;
    r_pen = m_pen - p0; r_unb = m_unb - u0; r_busy = m_busy - b0;
  endtask

  typedef struct packed {
    logic [7:0] xc; logic [7:0] yc; logic [1:0] sc;
    logic intens; logic esc; logic [9:0] x0; logic [9:0] y0;
  } vec_t;

  localparam vec_t VT [6] = '{
    '{8'h05, 8'h83, 2'd0, 1'b1, 1'b0, 10'd100, 10'd200},
    '{8'hC0, 8'h7F, 2'd1, 1'b0, 1'b1, 10'd400, 10'd300},
    '{8'h00, 8'h00, 2'd0, 1'b1, 1'b0, 10'd10,  10'd10},
    '{8'h64, 8'h91, 2'd2, 1'b1, 1'b1, 10'd50,  10'd600},
    '{8'h03, 8'h09, 2'd3, 1'b1, 1'b0, 10'd0,   10'd0},
    '{8'h80, 8'h01, 2'd0, 1'b0, 1'b1, 10'd5,   10'd5}
  };

  initial begin
    repeat (200000) @(posedge clk);
    chk("watchdog", "global timeout", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R10 reset state
    repeat (3) @(negedge clk);
    chk("R10", "busy", busy_o, 0);
    chk("R10", "pos_x", pos_x_o, 0);
    chk("R10", "unblank", unblank_o, 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R10", "pos_y", pos_y_o, 0);
    chk("R10", "done", done_o | esc_o | edge_irq_o | pen_irq_o, 0);

    // table walk: R1 R2 R3 R4 R5 R7
    foreach (VT[i]) begin
      int mx, my, sx, sy, pl;
      mx = VT[i].xc[6:0]; my = VT[i].yc[6:0];
      sx = VT[i].xc[7] ? -1 : 1; sy = VT[i].yc[7] ? -1 : 1;
      pl = pass_len(mx, my);
      run({VT[i].xc, VT[i].yc, VT[i].intens, VT[i].esc}, 1'b0, VT[i].sc,
          VT[i].x0, VT[i].y0, 1'b0, -1);
      chk("R4", "x end", pos_x_o, VT[i].x0 + sx * mx * (1 << VT[i].sc));
      chk("R4", "y end", pos_y_o, VT[i].y0 + sy * my * (1 << VT[i].sc));
      chk("R3", "busy cycles", r_busy, pl * LOOP);
      chk("R5", "unblank count", r_unb, VT[i].intens ? pl - 1 : 0);
      chk("R7", "done", r_done, 1);
      chk("R7", "esc", r_esc, VT[i].esc);
      chk("R2", "no edge", r_edge, 0);
    end

    // R1 start/preset ignored while busy
    fork
      run({8'h40, 8'h00, 2'b00}, 1'b0, 2'd0, 300, 300, 1'b0, -1);
      begin
        repeat (20) @(negedge clk);
        start_i = 1'b1; pos_set_i = 1'b1; word_i = {8'h01, 8'h01, 2'b00};
        @(negedge clk);
        start_i = 1'b0; pos_set_i = 1'b0;
      end
    join
    chk("R1", "x after busy start", pos_x_o, 364);
    chk("R1", "y after busy start", pos_y_o, 300);
    chk("R1", "busy cycles", r_busy, 128 * LOOP);

    // R6 single edge, X high side
    run({8'h0A, 8'h00, 2'b11}, 1'b0, 2'd0, 1020, 0, 1'b0, -1);
    chk("R6", "edge irq", r_edge, 1);
    chk("R6", "esc", r_esc, 1);
    chk("R6", "no done", r_done, 0);
    // R6 single edge, Y low side
    run({8'h00, 8'h83, 2'b00}, 1'b0, 2'd0, 0, 2, 1'b0, -1);
    chk("R6", "edge irq y", r_edge, 1);
    chk("R6", "no done y", r_done, 0);

    // R8 continue until edge
    run({8'h14, 8'h00, 2'b00}, 1'b1, 2'd3, 500, 500, 1'b0, -1);
    chk("R8", "done", r_done, 1);
    chk("R8", "esc", r_esc, 1);
    chk("R8", "no irq", r_edge, 0);
    chk("R8", "multi pass", (r_busy > 32 * LOOP) ? 1 : 0, 1);
    chk("R8", "y held", pos_y_o, 500);

    // R9 pen stop
    run({8'h64, 8'h00, 2'b10}, 1'b0, 2'd0, 100, 100, 1'b1, 20);
    chk("R9", "pen irq", r_pen, 1);
    chk("R9", "no done", r_done, 0);
    chk("R9", "stop soon", (r_busy <= 6 * LOOP) ? 1 : 0, 1);
    chk("R9", "whole loops", r_busy % LOOP, 0);
    // R9 pen disabled: hit ignored
    run({8'h64, 8'h00, 2'b10}, 1'b0, 2'd0, 100, 100, 1'b0, 20);
    chk("R9", "disabled pen irq", r_pen, 0);
    chk("R9", "disabled done", r_done, 1);
    chk("R9", "disabled x", pos_x_o, 200);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule